// File: doc/BRIEF.md
# Transmit Buffer Credit Tracker

This block decides when a new transmit-buffer element may be handed to a producer. It keeps a running count of elements that have been handed out but have not yet left the chip. It does not need one completion pulse per element. Instead it watches a free-running 8-bit sequence counter that the transmit hardware advances as elements depart. On every cycle it takes the wrapping difference against the last value it saw and returns that many credits.

After reset the tracker stays idle until the sequence register shows its valid flag. It then records the counter as its baseline and publishes the first element index, which is the counter modulo the partition size. From then on, a requester raises a request line and receives a one-cycle acknowledge. The acknowledge is given only while the refreshed in-flight count is at or below a threshold that sits below the partition size, so the partition is never overrun. If the arithmetic ever shows more completions than outstanding elements, or a count above the partition size, a sticky error flag is raised.

Top module: `tx_credit_tracker`

## Requirements
- R1: While the sequence input has bit 31 clear and no baseline has been taken, `ready_o` stays 0, `gnt_o` stays 0 and `inflight_o` stays 0, whatever `req_i` does.
- R2: On the first clock edge where `seq_i` bit 31 is 1 (with the tracker not yet ready), `ready_o` becomes 1 and stays 1. `start_idx_o` becomes `seq_i[6:0]` and holds that value until reset. `inflight_o` is 0, and `seq_i[7:0]` becomes the baseline.
- R3: On every later edge, the completed amount is (`seq_i[7:0]` minus baseline) modulo 256. This amount is subtracted from the in-flight count, and the baseline becomes `seq_i[7:0]`. This holds across the 255-to-0 wrap.
- R4: An acknowledge is issued only when `req_i` is 1 and the count after that edge's refresh is 96 or less. Above 96 no acknowledge is issued and the count keeps being refreshed.
- R5: Each acknowledge adds exactly one to the in-flight count, on the same edge that applies that cycle's refresh.
- R6: `gnt_o` is high for exactly one cycle per grant. No grant is made on the edge right after a grant, so a held request gets at most one acknowledge every two cycles.
- R7: `err_o` rises and stays 1 until reset if the completions exceed the outstanding count, in which case the count clamps to 0. It also rises if the count would exceed 128.
- R8: During and right after reset, `ready_o`, `gnt_o`, `err_o`, `inflight_o` and `start_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_i | input | 32 | Sequence register: bit 31 valid flag, bits 7:0 departure counter |
| req_i | input | 1 | Request for one transmit-buffer element |
| gnt_o | output | 1 | One-cycle acknowledge of a request |
| ready_o | output | 1 | Baseline taken, tracker running |
| start_idx_o | output | 7 | First element index (counter modulo 128) |
| inflight_o | output | 8 | Elements issued but not yet departed |
| err_o | output | 1 | Sticky overflow/underflow error |

## Verification
On every cycle, the assertions check the following. No acknowledge appears before start-up. The ready flag, the start index and the error flag never change back once set. Acknowledges are single pulses and never coincide with a count above threshold plus one. The count never exceeds the partition size. Only the bench's scenarios can show that the right number of credits comes back across the counter wrap, that the threshold boundary falls exactly at 96, that an invalid sequence word is ignored, and that an oversized completion amount clamps the count and raises the error flag.

// File: rtl/txc_pkg.sv
// Package: shared constants and types for the transmit credit tracker.
// Assumes: an 8-bit departure counter inside a 32-bit sequence word.
package txc_pkg;
    localparam int unsigned SEQ_WORD_W = 32;
    localparam int unsigned CTR_W      = 8;

    typedef logic [CTR_W-1:0] ctr_t;
endpackage

// File: rtl/txc_seq_delta.sv
// Module: txc_seq_delta
// Computes how many elements departed since the last sample as the wrapping
// difference of the departure counter. Assumes fewer than 2**W departures
// happen between two samples.
module txc_seq_delta #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    output logic [W-1:0] done_o
);
    // Modular subtraction; the natural width truncation performs the wrap.
    always_comb begin
        done_o = cur_i - prev_i;
    end
endmodule

// File: rtl/txc_admit.sv
// Module: txc_admit
// Applies the returned credits to the outstanding count and decides admission.
// Assumes THRESH < PART and that busy_i blocks a grant right after a grant.
module txc_admit #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DONE_W = 8,
    parameter int unsigned THRESH = 96,
    parameter int unsigned PART   = 128
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DONE_W-1:0] done_i,
    input  logic              req_i,
    input  logic              busy_i,
    output logic [CNT_W-1:0]  cnt_nxt_o,
    output logic              grant_o,
    output logic              ovf_o
);
    localparam int unsigned EW = ((CNT_W > DONE_W) ? CNT_W : DONE_W) + 1;

    logic [EW-1:0] cnt_e;
    logic [EW-1:0] done_e;
    logic [EW-1:0] base;
    logic [EW-1:0] nxt;
    logic          under;

    // Widen both operands so comparisons and subtraction cannot wrap.
    always_comb begin
        cnt_e  = EW'(cnt_i);
        done_e = EW'(done_i);
    end

    // Refresh the count, clamping at zero when completions exceed it.
    always_comb begin
        under = done_e > cnt_e;
        base  = under ? '0 : (cnt_e - done_e);
    end

    // Admit one element when requested and the refreshed count allows it.
    always_comb begin
        grant_o = req_i && !busy_i && (base <= EW'(THRESH));
        nxt     = base + {{(EW-1){1'b0}}, grant_o};
    end

    // Flag inconsistent arithmetic and keep the count within the partition.
    always_comb begin
        ovf_o     = under || (nxt > EW'(PART));
        cnt_nxt_o = (nxt > EW'(PART)) ? CNT_W'(PART) : nxt[CNT_W-1:0];
    end
endmodule

// File: rtl/tx_credit_tracker.sv
// Module: tx_credit_tracker (top)
// Tracks transmit-buffer elements issued but not yet departed by sampling a
// free-running departure counter. Waits for the valid flag at start-up, then
// takes a baseline and publishes the first element index. Assumes one
// requester that may hold req_i; each acknowledge is a single-cycle pulse.
module tx_credit_tracker #(
    parameter int unsigned PART_SIZE = 128,
    parameter int unsigned THRESH    = 96,
    parameter int unsigned VALID_BIT = 31
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [txc_pkg::SEQ_WORD_W-1:0]     seq_i,
    input  logic                               req_i,
    output logic                               gnt_o,
    output logic                               ready_o,
    output logic [$clog2(PART_SIZE)-1:0]       start_idx_o,
    output logic [$clog2(PART_SIZE+1)-1:0]     inflight_o,
    output logic                               err_o
);
    import txc_pkg::*;

    localparam int unsigned IDX_W = $clog2(PART_SIZE);
    localparam int unsigned CNT_W = $clog2(PART_SIZE + 1);

    ctr_t             prev_q;
    ctr_t             cur;
    ctr_t             done;
    logic [CNT_W-1:0] cnt_nxt;
    logic             grant;
    logic             ovf;

    // Extract the departure counter from the sequence word.
    always_comb begin
        cur = seq_i[CTR_W-1:0];
    end

    txc_seq_delta #(
        .W (CTR_W)
    ) u_delta (
        .cur_i  (cur),
        .prev_i (prev_q),
        .done_o (done)
    );

    txc_admit #(
        .CNT_W  (CNT_W),
        .DONE_W (CTR_W),
        .THRESH (THRESH),
        .PART   (PART_SIZE)
    ) u_admit (
        .cnt_i     (inflight_o),
        .done_i    (done),
        .req_i     (req_i),
        .busy_i    (gnt_o),
        .cnt_nxt_o (cnt_nxt),
        .grant_o   (grant),
        .ovf_o     (ovf)
    );

    // Start-up baseline capture, then per-cycle refresh and admission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_o     <= 1'b0;
            prev_q      <= '0;
            start_idx_o <= '0;
            inflight_o  <= '0;
            gnt_o       <= 1'b0;
            err_o       <= 1'b0;
        end else if (!ready_o) begin
            gnt_o <= 1'b0;
            if (seq_i[VALID_BIT]) begin
                ready_o     <= 1'b1;
                prev_q      <= cur;
                start_idx_o <= seq_i[IDX_W-1:0];
                inflight_o  <= '0;
            end
        end else begin
            prev_q     <= cur;
            inflight_o <= cnt_nxt;
            gnt_o      <= grant;
            if (ovf) begin
                err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_credit_tracker_chk.sv
// Module: tx_credit_tracker_chk
// Checker with cycle-level properties of the credit tracker, bound to the top.
module tx_credit_tracker_chk #(
    parameter int unsigned PART_SIZE = 128,
    parameter int unsigned THRESH    = 96,
    parameter int unsigned IDX_W     = 7,
    parameter int unsigned CNT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gnt_o,
    input logic             ready_o,
    input logic [IDX_W-1:0] start_idx_o,
    input logic [CNT_W-1:0] inflight_o,
    input logic             err_o
);
    AST_NO_GNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (!gnt_o && inflight_o == '0)); // R1
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R2
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> $stable(start_idx_o)); // R2
    AST_GNT_UNDER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o |-> (inflight_o <= CNT_W'(THRESH + 1))); // R4
    AST_GNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o |=> !gnt_o); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_o <= CNT_W'(PART_SIZE)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R7
endmodule

bind tx_credit_tracker tx_credit_tracker_chk #(
    .PART_SIZE (PART_SIZE),
    .THRESH    (THRESH),
    .IDX_W     ($clog2(PART_SIZE)),
    .CNT_W     ($clog2(PART_SIZE + 1))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_o       (gnt_o),
    .ready_o     (ready_o),
    .start_idx_o (start_idx_o),
    .inflight_o  (inflight_o),
    .err_o       (err_o)
);

// File: tb/tx_credit_tracker_tb_top.sv
// Bench: scoreboard. The driver task applies one cycle of stimulus and pushes
// the expected outputs, computed from the requirements, into a queue; the
// monitor pops and compares after each rising edge.
module tx_credit_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] seq = 32'h0;
    logic        req = 1'b0;
    logic        gnt;
    logic        ready;
    logic [6:0]  start_idx;
    logic [7:0]  inflight;
    logic        err;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic       gnt;
        logic       ready;
        logic [6:0] idx;
        logic [7:0] infl;
        logic       err;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state derived from the requirements.
    logic       m_ready = 1'b0;
    logic [7:0] m_prev  = 8'h0;
    logic [6:0] m_idx   = 7'h0;
    int         m_infl  = 0;
    logic       m_gnt   = 1'b0;
    logic       m_err   = 1'b0;

    always #5 clk = ~clk;

    tx_credit_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_i       (seq),
        .req_i       (req),
        .gnt_o       (gnt),
        .ready_o     (ready),
        .start_idx_o (start_idx),
        .inflight_o  (inflight),
        .err_o       (err)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic drive(input logic [31:0] s, input logic r, input string tag);
        exp_t e;
        int   done;
        int   base;
        logic g;
        @(negedge clk);
        seq = s;
        req = r;
        g = 1'b0;
        if (!m_ready) begin
            if (s[31]) begin
                m_ready = 1'b1;
                m_prev  = s[7:0];
                m_idx   = s[6:0];
                m_infl  = 0;
            end
        end else begin
            done = (int'(s[7:0]) - int'(m_prev) + 256) % 256;
            m_prev = s[7:0];
            if (done > m_infl) begin
                m_err = 1'b1;
                base  = 0;
            end else begin
                base = m_infl - done;
            end
            g = r && !m_gnt && (base <= 96);
            m_infl = base + (g ? 1 : 0);
        end
        m_gnt = g;
        e.gnt = m_gnt; e.ready = m_ready; e.idx = m_idx;
        e.infl = m_infl[7:0]; e.err = m_err; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs against the oldest expected item after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(gnt == e.gnt, e.tag, "gnt", int'(gnt), int'(e.gnt));
                check(ready == e.ready, e.tag, "ready", int'(ready), int'(e.ready));
                check(inflight == e.infl, e.tag, "inflight", int'(inflight), int'(e.infl));
                check(err == e.err, e.tag, "err", int'(err), int'(e.err));
                if (e.ready)
                    check(start_idx == e.idx, e.tag, "start_idx", int'(start_idx), int'(e.idx));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    int grants_seen = 0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset values.
        check(!ready && !gnt && !err, "R8", "flags", int'({ready, gnt, err}), 0);
        check(inflight == 8'd0, "R8", "inflight", int'(inflight), 0);
        check(start_idx == 7'd0, "R8", "start_idx", int'(start_idx), 0);
        rst_n = 1'b1;

        // R1: invalid sequence words are ignored, requests get nothing.
        for (int i = 0; i < 4; i++) drive(32'h0000_00C5 + i, 1'b1, "R1");

        // R2: baseline taken on the first valid word; index = 0xC5 mod 128.
        drive(32'h8000_00C5, 1'b0, "R2");
        drive(32'h8000_00C5, 1'b0, "R2");

        // R4/R5/R6: held request fills the credit window up to the threshold.
        for (int i = 0; i < 200; i++) begin
            drive(32'h8000_00C5, 1'b1, "R4");
            if (m_gnt) grants_seen++;
        end
        check(grants_seen == 97, "R4", "grant total", grants_seen, 97);
        check(m_infl == 97, "R5", "model count", m_infl, 97);

        // R3: counter wraps 0xC5 -> 0x02, returning 61 credits, grants resume.
        drive(32'h8000_0002, 1'b1, "R3");
        drive(32'h8000_0002, 1'b0, "R3");
        drive(32'h8000_0005, 1'b0, "R3");

        // R6: back-to-back request cycles yield alternating acknowledges.
        for (int i = 0; i < 6; i++) drive(32'h8000_0005, 1'b1, "R6");
        drive(32'h8000_0005, 1'b0, "R6");

        // R2: a later invalid word does not touch the start index or ready.
        drive(32'h0000_0005, 1'b0, "R2");

        // R7: more completions than outstanding elements -> clamp and error.
        drive(32'h8000_00F0, 1'b0, "R7");
        for (int i = 0; i < 3; i++) drive(32'h8000_00F0, 1'b0, "R7");
        drive(32'h8000_00F0, 1'b1, "R7");
        drive(32'h8000_00F0, 1'b0, "R7");

        repeat (3) @(posedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule